// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a small set of registers of which each exists once per hardware unit, in a grid of groups and instances. All copies of one such register share a single bus address. A steering word, itself reachable on the same bus, names one group, one instance and a broadcast flag. With the flag set, a write to a replicated address lands in every copy. With the flag clear, the write lands only in the steered copy. A read always returns the single steered copy and ignores the flag.

A presence vector input marks each unit as available, or as fused off or power-gated. An access aimed at an absent unit is terminated. A read returns zero, a unicast write is dropped, and a broadcast write skips that copy. The expected software sequence is to program the steering word, make the access, and after a unicast write put the word back into broadcast mode. Addresses outside the replicated page map to ordinary single registers or read as zero.

Top module: `repl_reg_bank`

## Requirements
- R1: After reset the steering word reads 0x8000_0000, with broadcast set and group and instance both zero. Every copy of every replicated register and every ordinary register reads zero.
- R2: The steering word is at address 0x00. Bit 31 is the broadcast flag. The group ID sits at bit 8 upward and the instance ID at bit 0 upward, each as wide as needed (2 bits by default). All other bits read zero.
- R3: A write to replicated address 0x10+k while broadcast is set updates every present copy of register k with the same value.
- R4: A write to a replicated address while broadcast is clear updates only the copy at the steered group and instance, and leaves every other copy unchanged.
- R5: A read of a replicated address returns the steered copy whether the broadcast flag is set or clear.
- R6: A read steered to a unit whose presence bit (index group*instances+instance) is 0 returns zero.
- R7: A unicast write steered to an absent unit is dropped. That copy keeps its earlier value, which shows again once the unit becomes present, and no other copy changes.
- R8: A broadcast write leaves the copies of absent units at their earlier value.
- R9: The ordinary registers at 0x20+j read back what was last written to them, whatever the steering word holds.
- R10: A write to an unmapped address changes no register, and a read of one returns zero.
- R11: A write to one replicated register does not change any copy of another replicated register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| unit_present | input | 16 | One bit per group/instance unit; 1 means the unit is available |

## Verification
On every cycle the assertions check three things inside the instance store: a unicast write enables at most one copy, no absent copy is ever enabled, and a broadcast write enables exactly the present copies. They also check that copies, ordinary registers and the steering word hold their value when nothing writes them, and that a steered read of an absent unit yields zero. Only the bench scenarios can show that the values actually land where they belong. These scenarios sweep every group and instance with distinct patterns, toggle the presence vector to reveal what dropped and skipped writes left behind, and read through both settings of the broadcast flag.

// File: rtl/repl_bank_pkg.sv
package repl_bank_pkg;
  localparam int ADDR_W = 8;
  // address pages: upper nibble selects the page, lower nibble the register
  localparam logic [7:0] STEER_ADDR = 8'h00;
  localparam logic [3:0] REPL_PAGE  = 4'h1;
  localparam logic [3:0] PLAIN_PAGE = 4'h2;
  // steering word field positions
  localparam int BCAST_BIT = 31;
  localparam int GRP_LSB   = 8;
  localparam int INST_LSB  = 0;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/repl_steer_sel.sv
module repl_steer_sel #(
  parameter int NUM_GRP  = 4,
  parameter int NUM_INST = 4,
  localparam int GW = repl_bank_pkg::idx_w(NUM_GRP),
  localparam int IW = repl_bank_pkg::idx_w(NUM_INST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic          bcast_d,
  input  logic [GW-1:0] grp_d,
  input  logic [IW-1:0] inst_d,
  output logic          bcast_q,
  output logic [GW-1:0] grp_q,
  output logic [IW-1:0] inst_q
);
  logic          bcast_n;
  logic [GW-1:0] grp_n;
  logic [IW-1:0] inst_n;

  always_comb begin
    bcast_n = bcast_q;
    grp_n   = grp_q;
    inst_n  = inst_q;
    if (sel_we) begin
      bcast_n = bcast_d;
      grp_n   = grp_d;
      inst_n  = inst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcast_q <= 1'b1;
      grp_q   <= '0;
      inst_q  <= '0;
    end else begin
      bcast_q <= bcast_n;
      grp_q   <= grp_n;
      inst_q  <= inst_n;
    end
  end

  // steering fields only move on a steering-word write
  p_steer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> ($stable(bcast_q) && $stable(grp_q) && $stable(inst_q)));
endmodule

// File: rtl/repl_inst_store.sv
module repl_inst_store #(
  parameter int NUM_GRP  = 4,
  parameter int NUM_INST = 4,
  parameter int DATA_W   = 32,
  localparam int NU = NUM_GRP * NUM_INST,
  localparam int GW = repl_bank_pkg::idx_w(NUM_GRP),
  localparam int IW = repl_bank_pkg::idx_w(NUM_INST),
  localparam int UW = repl_bank_pkg::idx_w(NU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              bcast,
  input  logic [GW-1:0]     grp,
  input  logic [IW-1:0]     inst,
  input  logic [NU-1:0]     present,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] copy_q [NU];
  logic [DATA_W-1:0] copy_n [NU];
  logic [NU-1:0]     copy_we;
  logic [UW-1:0]     tgt_idx;
  logic              tgt_ok;

  always_comb begin
    int t;
    t       = int'(grp) * NUM_INST + int'(inst);
    tgt_ok  = (int'(grp) < NUM_GRP) && (int'(inst) < NUM_INST);
    tgt_idx = UW'(t);
  end

  // write fan-out: broadcast reaches all present copies, unicast one
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      if (bcast) copy_we[u] = wr_hit && present[u];
      else       copy_we[u] = wr_hit && tgt_ok && (tgt_idx == UW'(u)) && present[u];
    end
  end

  always_comb begin
    for (int u = 0; u < NU; u++)
      copy_n[u] = copy_we[u] ? wdata : copy_q[u];
  end

  for (genvar u = 0; u < NU; u++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) copy_q[u] <= '0;
      else        copy_q[u] <= copy_n[u];
    end

    p_copy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_we[u] |=> $stable(copy_q[u]));
  end

  // read mux: always the steered copy, zero when terminated
  always_comb begin
    if (tgt_ok && present[tgt_idx]) rdata = copy_q[tgt_idx];
    else                            rdata = '0;
  end

  p_ucast_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bcast) |-> ($countones(copy_we) <= 1));
  p_absent_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_we & ~present) == '0);
  p_bcast_fanout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bcast) |-> (copy_we == present));
endmodule

// File: rtl/repl_plain_regs.sv
module repl_plain_regs #(
  parameter int NUM_PLAIN = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [3:0]        ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] reg_q [NUM_PLAIN];
  logic [DATA_W-1:0] reg_n [NUM_PLAIN];
  logic [NUM_PLAIN-1:0] reg_we;

  always_comb begin
    for (int j = 0; j < NUM_PLAIN; j++) begin
      reg_we[j] = wr_hit && (ofs == 4'(j));
      reg_n[j]  = reg_we[j] ? wdata : reg_q[j];
    end
  end

  for (genvar j = 0; j < NUM_PLAIN; j++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[j] <= '0;
      else        reg_q[j] <= reg_n[j];
    end

    p_plain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we[j] |=> $stable(reg_q[j]));
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < NUM_PLAIN; j++)
      if (ofs == 4'(j)) rdata = reg_q[j];
  end
endmodule

// File: rtl/repl_reg_bank.sv
module repl_reg_bank #(
  parameter int NUM_GRP   = 4,
  parameter int NUM_INST  = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_REPL  = 2,
  parameter int NUM_PLAIN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [7:0]                   addr,
  input  logic                         wr_en,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [NUM_GRP*NUM_INST-1:0]  unit_present
);
  import repl_bank_pkg::*;
  localparam int NU = NUM_GRP * NUM_INST;
  localparam int GW = idx_w(NUM_GRP);
  localparam int IW = idx_w(NUM_INST);
  localparam int UW = idx_w(NU);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  // address decode
  logic [3:0] page, ofs;
  logic steer_hit, repl_hit, plain_hit;
  always_comb begin
    page      = addr[7:4];
    ofs       = addr[3:0];
    steer_hit = (addr == STEER_ADDR);
    repl_hit  = (page == REPL_PAGE)  && (int'(ofs) < NUM_REPL);
    plain_hit = (page == PLAIN_PAGE) && (int'(ofs) < NUM_PLAIN);
  end

  logic          bcast;
  logic [GW-1:0] grp;
  logic [IW-1:0] inst;

  repl_steer_sel #(.NUM_GRP(NUM_GRP), .NUM_INST(NUM_INST)) u_sel (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .sel_we  (wr_en && steer_hit),
    .bcast_d (wr_data[BCAST_BIT]),
    .grp_d   (wr_data[GRP_LSB +: GW]),
    .inst_d  (wr_data[INST_LSB +: IW]),
    .bcast_q (bcast),
    .grp_q   (grp),
    .inst_q  (inst)
  );

  logic [DATA_W-1:0] steer_word;
  always_comb begin
    steer_word = '0;
    steer_word[BCAST_BIT]       = bcast;
    steer_word[GRP_LSB +: GW]   = grp;
    steer_word[INST_LSB +: IW]  = inst;
  end

  logic [DATA_W-1:0] repl_rd [NUM_REPL];
  for (genvar k = 0; k < NUM_REPL; k++) begin : g_repl
    repl_inst_store #(.NUM_GRP(NUM_GRP), .NUM_INST(NUM_INST), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .wr_hit  (wr_en && repl_hit && (ofs == 4'(k))),
      .bcast   (bcast),
      .grp     (grp),
      .inst    (inst),
      .present (unit_present),
      .wdata   (wr_data),
      .rdata   (repl_rd[k])
    );
  end

  logic [DATA_W-1:0] plain_rd;
  repl_plain_regs #(.NUM_PLAIN(NUM_PLAIN), .DATA_W(DATA_W)) u_plain (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_hit (wr_en && plain_hit),
    .ofs    (ofs),
    .wdata  (wr_data),
    .rdata  (plain_rd)
  );

  always_comb begin
    rd_data = '0;
    if (steer_hit) rd_data = steer_word;
    else if (plain_hit) rd_data = plain_rd;
    else if (repl_hit) begin
      for (int k = 0; k < NUM_REPL; k++)
        if (ofs == 4'(k)) rd_data = repl_rd[k];
    end
  end

  // presence of the steered unit, derived separately from the store
  logic [UW-1:0] steer_idx;
  logic          steer_present;
  always_comb begin
    steer_idx     = UW'(int'(grp) * NUM_INST + int'(inst));
    steer_present = unit_present[steer_idx];
  end

  p_absent_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (repl_hit && !steer_present) |-> (rd_data == '0));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!steer_hit && !repl_hit && !plain_hit) |-> (rd_data == '0));
endmodule

// File: tb/repl_reg_bank_bench.sv
`timescale 1ns/1ps
module repl_reg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [15:0] unit_present;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_rep [2][16];
  logic [31:0] exp_plain [4];

  always #2.5 clk = ~clk;

  repl_reg_bank u_repl_reg_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .unit_present(unit_present)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 d = rd_data;
  endtask

  task automatic steer(input int g, input int i, input bit bc);
    wr(8'h00, {bc, 15'd0, 8'(g), 8'(i)});
  endtask

  // sweep all units of replicated register k, both flag settings
  task automatic sweep(input string req, input int k);
    logic [31:0] v;
    for (int u = 0; u < 16; u++) begin
      for (int bc = 0; bc < 2; bc++) begin
        steer(u / 4, u % 4, bit'(bc));
        rd(8'h10 + 8'(k), v);
        check(req, v, unit_present[u] ? exp_rep[k][u] : 32'h0);
      end
    end
    steer(0, 0, 1'b1);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; unit_present = 16'hFFFF;
    for (int k = 0; k < 2; k++) for (int u = 0; u < 16; u++) exp_rep[k][u] = '0;
    for (int j = 0; j < 4; j++) exp_plain[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h00, v); check("R1 steer reset", v, 32'h8000_0000);
    for (int j = 0; j < 4; j++) begin rd(8'h20 + 8'(j), v); check("R1 plain reset", v, 0); end
    sweep("R1 copies reset", 0);
    sweep("R1 copies reset", 1);

    // R2 field layout
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 mask", v, 32'h8000_0303);
    wr(8'h00, 32'h0000_0201); rd(8'h00, v); check("R2 fields", v, 32'h0000_0201);
    steer(0, 0, 1'b1);

    // R3 broadcast write, all present
    wr(8'h10, 32'hCAFE_0001);
    for (int u = 0; u < 16; u++) exp_rep[0][u] = 32'hCAFE_0001;
    sweep("R3 broadcast", 0);

    // R4/R5 unicast writes of distinct values, read back in both modes
    for (int u = 0; u < 16; u++) begin
      steer(u / 4, u % 4, 1'b0);
      wr(8'h10, 32'h1000 + 32'(u * 37));
      exp_rep[0][u] = 32'h1000 + 32'(u * 37);
      steer(0, 0, 1'b1);
    end
    sweep("R4 R5 unicast", 0);
    sweep("R11 other reg untouched", 1);

    // R6 absent units read zero
    unit_present = 16'hA5C3;
    sweep("R6 absent zero", 0);

    // R7 unicast writes to absent units dropped
    for (int u = 0; u < 16; u++) if (!unit_present[u]) begin
      steer(u / 4, u % 4, 1'b0);
      wr(8'h10, 32'hDEAD_0000 + 32'(u));
      steer(0, 0, 1'b1);
    end
    sweep("R7 dropped", 0);
    unit_present = 16'hFFFF;
    sweep("R7 old value kept", 0);

    // R8 broadcast skips absent units
    unit_present = 16'h3C5A;
    wr(8'h11, 32'h5555_AAAA);
    for (int u = 0; u < 16; u++) if (unit_present[u]) exp_rep[1][u] = 32'h5555_AAAA;
    unit_present = 16'hFFFF;
    sweep("R8 skipped", 1);
    sweep("R11 reg0 unchanged", 0);

    // R9 ordinary registers under various steering
    for (int j = 0; j < 4; j++) begin
      steer(j, 3 - j, bit'(j % 2));
      wr(8'h20 + 8'(j), 32'h0BAD_F00D ^ 32'(j << 12));
      exp_plain[j] = 32'h0BAD_F00D ^ 32'(j << 12);
    end
    steer(0, 0, 1'b1);
    for (int j = 0; j < 4; j++) begin rd(8'h20 + 8'(j), v); check("R9 plain", v, exp_plain[j]); end

    // R10 unmapped addresses
    wr(8'h05, 32'h1234_5678); wr(8'h12, 32'h1234_5678);
    wr(8'h24, 32'h1234_5678); wr(8'hF0, 32'h1234_5678);
    rd(8'h05, v); check("R10 unmapped read", v, 0);
    rd(8'h12, v); check("R10 unmapped read", v, 0);
    rd(8'h24, v); check("R10 unmapped read", v, 0);
    rd(8'h00, v); check("R10 steer untouched", v, 32'h8000_0000);
    for (int j = 0; j < 4; j++) begin rd(8'h20 + 8'(j), v); check("R10 plain untouched", v, exp_plain[j]); end
    sweep("R10 copies untouched", 0);
    sweep("R10 copies untouched", 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule